// File: doc/BRIEF.md
# Timer Input Capture Channel

This block pairs a free-running counter, advanced by a programmable timebase divider, with a single capture channel. One of two external inputs is selected. It passes through a two-stage synchroniser and then a stability filter. The filtered level is watched for rising or falling transitions. Each accepted transition may be thinned by an edge divider. The edges that survive copy the running count into a capture register.

A capture raises a pending flag. A second capture that lands before software has serviced the first also raises a sticky overcapture flag. Two separate enables route the pending flag to an interrupt line and to a DMA request line. Software reaches everything through a four-word register window with single-cycle reads and writes. Reading the captured value acknowledges the pending flag, and writing zeros into the status word clears the chosen flags.

Top module: `icap_unit`

## Requirements
- R1: The count register (address 3, read) advances by one every P+1 clock cycles, where P is the timebase divider value written to address 3. After reset P is 0.
- R2: An accepted edge copies the count into the capture register (address 2). With filter length N, an input change driven just after count value C is read is captured as C+1+max(N,1).
- R3: Polarity bit (control bit 1) at 0 accepts only rising filtered edges. At 1 it accepts only falling filtered edges.
- R4: The filter field (control bits 7:4), holding N from 1 to 15, changes the filtered level only after N consecutive synchronised samples differ from it. A pulse shorter than N samples causes no capture. N equal to 0 disables filtering.
- R5: The edge divider field (control bits 3:2) captures on every accepted edge for 00, and on every 2nd, 4th and 8th accepted edge for 01, 10 and 11. The edge count restarts whenever the channel enable is 0.
- R6: A capture sets the pending flag (status bit 0). irq is high while pending is set and interrupt enable (control bit 9) is 1. dma_req is high while pending is set and DMA enable (control bit 10) is 1. The two enables act independently.
- R7: A capture while pending is already set also sets the overcapture flag (status bit 1), which stays set until software clears it.
- R8: Pending clears when a status write has bit 0 equal to 0, or when the capture register is read.
- R9: Overcapture clears only on a status write with bit 1 equal to 0. Reading the capture register leaves it set.
- R10: The input select bit (control bit 8; 0 picks sig_in[0], 1 picks sig_in[1]) ignores writes while the channel enable (control bit 0) is 1.
- R11: After reset, the control, status and capture registers read 0, and irq and dma_req are low.
- R12: With the channel enable at 0, input edges cause no capture and leave the status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 2 | Asynchronous capture inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the acknowledge when the capture register is read) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 capture, 3 count/divider |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A corrupt filter counter or synchroniser shows up as a captured value offset from C+1+max(N,1). The error is visible at the first capture read after the faulty edge. A wrong edge-divider count appears as a pending flag that is present or missing after a set number of pulses. The bench polls the status word after each pulse, so this shows within one pulse. A flag register with the wrong clear or set priority shows at the next status read as a wrong pending or overcapture bit. It also shows on irq or dma_req within one cycle of the flag update.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_CAP  = 2'd2,
        A_TIME = 2'd3
    } reg_addr_e;

    // bit positions: en 0, pol 1, psc 3:2, filt 7:4, sel 8, irq_en 9, dma_en 10
    typedef struct packed {
        logic       dma_en;
        logic       irq_en;
        logic       sel;
        logic [3:0] filt;
        logic [1:0] psc;
        logic       pol;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/icap_timebase.sv
module icap_timebase #(
    parameter int CNT_W  = 16,
    parameter int TPSC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TPSC_W-1:0] div_val,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        logic [TPSC_W-1:0] pre;
        logic [CNT_W-1:0]  cnt;
    } tb_t;

    tb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.pre >= div_val) begin
            s_d.pre = '0;
            s_d.cnt = s_q.cnt + 1'b1;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
    parameter int SYNC_N = 2,
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw,
    input  logic [FILT_W-1:0] flen,
    output logic              rise,
    output logic              fall
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic [FILT_W-1:0] run;
        logic              level;
    } flt_t;

    flt_t s_d, s_q;
    logic sample;

    always_comb begin
        s_d      = s_q;
        sample   = s_q.sync[SYNC_N-1];
        s_d.sync = {s_q.sync[SYNC_N-2:0], raw};
        if (flen == '0) begin
            s_d.level = sample;
            s_d.run   = '0;
        end else if (sample != s_q.level) begin
            if (s_q.run >= flen - 1'b1) begin
                s_d.level = sample;
                s_d.run   = '0;
            end else begin
                s_d.run = s_q.run + 1'b1;
            end
        end else begin
            s_d.run = '0;
        end
        rise = s_d.level & ~s_q.level;
        fall = ~s_d.level & s_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/icap_edge_div.sv
module icap_edge_div #(
    parameter int DIV_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       edge_in,
    input  logic [1:0] psc,
    output logic       fire
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask  = DIV_W'((1 << psc) - 1);
        fire  = edge_in && ((cnt_q & mask) == mask);
        cnt_d = cnt_q;
        if (clr)          cnt_d = '0;
        else if (edge_in) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DW     = 16,
    parameter int TPSC_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    sig_in,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          dma_req
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic              pend;
        logic              ovr;
        logic [CNT_W-1:0]  cap;
        logic [TPSC_W-1:0] tdiv;
    } st_t;

    st_t s_d, s_q;

    logic [CNT_W-1:0] cnt_val;
    logic             raw_sel, f_rise, f_fall, edge_ok, cap_fire;
    ctrl_t            wr_ctrl;

    // named views for the bound checker
    logic             pend_q, ovr_q, chan_en, chan_sel;
    logic [CNT_W-1:0] cap_val;

    icap_timebase #(.CNT_W(CNT_W), .TPSC_W(TPSC_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .div_val(s_q.tdiv), .count(cnt_val)
    );

    assign raw_sel = s_q.ctrl.sel ? sig_in[1] : sig_in[0];

    icap_filter #(.SYNC_N(2), .FILT_W(4)) u_flt (
        .clk(clk), .rst_n(rst_n), .raw(raw_sel), .flen(s_q.ctrl.filt),
        .rise(f_rise), .fall(f_fall)
    );

    assign edge_ok = s_q.ctrl.en & (s_q.ctrl.pol ? f_fall : f_rise);

    icap_edge_div #(.DIV_W(3)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(~s_q.ctrl.en), .edge_in(edge_ok),
        .psc(s_q.ctrl.psc), .fire(cap_fire)
    );

    always_comb begin
        s_d     = s_q;
        wr_ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        if (s_q.ctrl.en) wr_ctrl.sel = s_q.ctrl.sel;

        if (reg_wr) begin
            case (reg_addr)
                A_CTRL:  s_d.ctrl = wr_ctrl;
                A_STAT: begin
                    s_d.pend = s_q.pend & reg_wdata[0];
                    s_d.ovr  = s_q.ovr  & reg_wdata[1];
                end
                A_TIME:  s_d.tdiv = reg_wdata[TPSC_W-1:0];
                default: ;
            endcase
        end
        if (reg_rd && reg_addr == A_CAP) s_d.pend = 1'b0;

        if (cap_fire) begin
            s_d.cap = cnt_val;
            if (s_d.pend) s_d.ovr = 1'b1;
            s_d.pend = 1'b1;
        end

        case (reg_addr)
            A_CTRL:  reg_rdata = DW'(s_q.ctrl);
            A_STAT:  reg_rdata = DW'({s_q.ovr, s_q.pend});
            A_CAP:   reg_rdata = DW'(s_q.cap);
            default: reg_rdata = DW'(cnt_val);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq      = s_q.pend & s_q.ctrl.irq_en;
    assign dma_req  = s_q.pend & s_q.ctrl.dma_en;
    assign pend_q   = s_q.pend;
    assign ovr_q    = s_q.ovr;
    assign chan_en  = s_q.ctrl.en;
    assign chan_sel = s_q.ctrl.sel;
    assign cap_val  = s_q.cap;
endmodule

// File: rtl/icap_checks.sv
module icap_checks #(
    parameter int CNT_W = 16,
    parameter int DW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_addr,
    input logic [DW-1:0]    reg_wdata,
    input logic             cap_fire,
    input logic             pend_q,
    input logic             ovr_q,
    input logic             chan_en,
    input logic             chan_sel,
    input logic [CNT_W-1:0] cap_val,
    input logic [CNT_W-1:0] cnt_val,
    input logic             irq,
    input logic             dma_req
);
    a_r2_cap_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> cap_val == $past(cnt_val));

    a_r6_pend_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> pend_q);

    a_r6_requests_need_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || dma_req) |-> pend_q);

    a_r7_ovr_on_double: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && pend_q && !reg_wr && !reg_rd) |=> ovr_q);

    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !(reg_wr && reg_addr == 2'd1 && !reg_wdata[1])) |=> ovr_q);

    a_r8_read_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2 && !cap_fire) |=> !pend_q);

    a_r10_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(chan_sel));

    a_r12_idle_no_cap: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> !cap_fire);
endmodule

bind icap_unit icap_checks #(.CNT_W(CNT_W), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cap_fire(cap_fire),
    .pend_q(pend_q), .ovr_q(ovr_q), .chan_en(chan_en), .chan_sel(chan_sel),
    .cap_val(cap_val), .cnt_val(cnt_val), .irq(irq), .dma_req(dma_req)
);

// File: tb/sim_icap_unit.sv
`timescale 1ns/1ps
module sim_icap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sig_in = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, dma_req;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    icap_unit u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cv(bit en, bit pol, bit [1:0] psc,
                                      bit [3:0] flen, bit sel, bit ie, bit de);
        return {5'd0, de, ie, sel, flen, psc, pol, en};
    endfunction

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // driver: change an input, push the expected capture when one is due
    task automatic drive(int idx, bit val, int flen, bit push);
        logic [15:0] c;
        int nn;
        nn = (flen < 1) ? 1 : flen;
        @(negedge clk);
        reg_addr = 2'd3;
        #1 c = reg_rdata;
        sig_in[idx] = val;
        if (push) exp_q.push_back(c + 16'(1 + nn));
        repeat (flen + 6) @(negedge clk);
    endtask

    // monitor side: read the capture register and compare with the queue head
    task automatic check_cap(string req);
        logic [15:0] v, e;
        rd(2'd2, v);
        if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL %s actual=%0h expected=<empty queue>", req, v);
        end else begin
            e = exp_q.pop_front();
            chk(req, v, e);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] d, c0, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        peek(2'd0, d); chk("R11 ctrl", d, 16'h0);
        peek(2'd1, d); chk("R11 status", d, 16'h0);
        peek(2'd2, d); chk("R11 capture", d, 16'h0);
        chk("R11 irq", 16'(irq), 16'h0);
        chk("R11 dma", 16'(dma_req), 16'h0);

        // R1 timebase divider P=2
        wr(2'd3, 16'd2);
        repeat (3) @(negedge clk);
        peek(2'd3, c0);
        repeat (5) @(negedge clk);
        peek(2'd3, c1);
        chk("R1 divided count", c1 - c0, 16'd2);
        wr(2'd3, 16'd0);
        repeat (2) @(negedge clk);
        peek(2'd3, c0);
        peek(2'd3, c1);
        chk("R1 undivided count", c1 - c0, 16'd1);

        // R12 disabled channel
        drive(0, 1'b1, 0, 1'b0);
        drive(0, 1'b0, 0, 1'b0);
        peek(2'd1, d); chk("R12 no capture while disabled", d, 16'h0);

        // R2 / R6 rising capture with interrupt only
        wr(2'd0, cv(1, 0, 2'b00, 4'd0, 0, 1, 0));
        drive(0, 1'b1, 0, 1'b1);
        peek(2'd1, d); chk("R6 pending set", d, 16'h1);
        chk("R6 irq high", 16'(irq), 16'h1);
        chk("R6 dma stays low", 16'(dma_req), 16'h0);
        check_cap("R2 rising capture value");
        peek(2'd1, d); chk("R8 read acknowledges", d, 16'h0);
        chk("R8 irq dropped", 16'(irq), 16'h0);
        drive(0, 1'b0, 0, 1'b0);
        peek(2'd1, d); chk("R3 falling ignored at pol 0", d, 16'h0);

        // R3 falling polarity
        wr(2'd0, cv(0, 1, 2'b00, 4'd0, 0, 0, 0));
        wr(2'd0, cv(1, 1, 2'b00, 4'd0, 0, 0, 0));
        drive(0, 1'b1, 0, 1'b0);
        peek(2'd1, d); chk("R3 rising ignored at pol 1", d, 16'h0);
        drive(0, 1'b0, 0, 1'b1);
        check_cap("R3 falling capture value");

        // R4 filter N=4
        wr(2'd0, cv(0, 0, 2'b00, 4'd4, 0, 0, 0));
        wr(2'd0, cv(1, 0, 2'b00, 4'd4, 0, 0, 0));
        @(negedge clk); sig_in[0] = 1'b1;
        repeat (3) @(negedge clk); sig_in[0] = 1'b0;
        repeat (12) @(negedge clk);
        peek(2'd1, d); chk("R4 short pulse rejected", d, 16'h0);
        drive(0, 1'b1, 4, 1'b1);
        check_cap("R4 filtered capture value");
        drive(0, 1'b0, 4, 1'b0);

        // R7 / R9 / R8 overcapture and clearing
        wr(2'd0, cv(0, 0, 2'b00, 4'd0, 0, 1, 1));
        wr(2'd0, cv(1, 0, 2'b00, 4'd0, 0, 1, 1));
        drive(0, 1'b1, 0, 1'b0);
        drive(0, 1'b0, 0, 1'b0);
        drive(0, 1'b1, 0, 1'b1);
        peek(2'd1, d); chk("R7 overcapture set", d, 16'h3);
        chk("R6 dma high", 16'(dma_req), 16'h1);
        check_cap("R2 latest capture kept");
        peek(2'd1, d); chk("R9 read keeps overcapture", d, 16'h2);
        wr(2'd1, 16'h1);
        peek(2'd1, d); chk("R9 write zero clears overcapture", d, 16'h0);
        drive(0, 1'b0, 0, 1'b0);
        drive(0, 1'b1, 0, 1'b0);
        peek(2'd1, d); chk("R6 pending again", d, 16'h1);
        wr(2'd1, 16'h2);
        peek(2'd1, d); chk("R8 write zero clears pending", d, 16'h0);
        chk("R8 dma dropped", 16'(dma_req), 16'h0);
        drive(0, 1'b0, 0, 1'b0);

        // R5 edge divider 01
        wr(2'd0, cv(0, 0, 2'b01, 4'd0, 0, 0, 0));
        wr(2'd0, cv(1, 0, 2'b01, 4'd0, 0, 0, 0));
        drive(0, 1'b1, 0, 1'b0);
        drive(0, 1'b0, 0, 1'b0);
        peek(2'd1, d); chk("R5 first edge skipped at 01", d, 16'h0);
        drive(0, 1'b1, 0, 1'b1);
        check_cap("R5 second edge captured at 01");
        drive(0, 1'b0, 0, 1'b0);

        // R5 edge divider 10 with restart on disable
        wr(2'd0, cv(0, 0, 2'b10, 4'd0, 0, 0, 0));
        wr(2'd0, cv(1, 0, 2'b10, 4'd0, 0, 0, 0));
        for (int i = 0; i < 3; i++) begin
            drive(0, 1'b1, 0, 1'b0);
            drive(0, 1'b0, 0, 1'b0);
        end
        wr(2'd0, cv(0, 0, 2'b10, 4'd0, 0, 0, 0));
        wr(2'd0, cv(1, 0, 2'b10, 4'd0, 0, 0, 0));
        for (int i = 0; i < 3; i++) begin
            drive(0, 1'b1, 0, 1'b0);
            drive(0, 1'b0, 0, 1'b0);
        end
        peek(2'd1, d); chk("R5 count restarted by disable", d, 16'h0);
        drive(0, 1'b1, 0, 1'b1);
        check_cap("R5 fourth edge captured at 10");
        drive(0, 1'b0, 0, 1'b0);

        // R10 select locked while enabled
        wr(2'd0, cv(0, 0, 2'b00, 4'd0, 0, 0, 0));
        wr(2'd0, cv(1, 0, 2'b00, 4'd0, 0, 0, 0));
        wr(2'd0, cv(1, 0, 2'b00, 4'd0, 1, 0, 0));
        peek(2'd0, d); chk("R10 select write ignored", 16'(d[8]), 16'h0);
        drive(1, 1'b1, 0, 1'b0);
        peek(2'd1, d); chk("R10 other input not watched", d, 16'h0);
        drive(1, 1'b0, 0, 1'b0);
        wr(2'd0, cv(0, 0, 2'b00, 4'd0, 1, 0, 0));
        wr(2'd0, cv(1, 0, 2'b00, 4'd0, 1, 0, 0));
        peek(2'd0, d); chk("R10 select written while disabled", 16'(d[8]), 16'h1);
        drive(1, 1'b1, 0, 1'b1);
        check_cap("R10 capture from second input");

        finish_run();
    end
endmodule